// File: doc/BRIEF.md
# Serial Link to Handshaken Byte Ports Bridge

This block joins a full-duplex, bit-serial point-to-point link to two independent byte-wide parallel ports. The input port accepts a byte from a local device under a valid/acknowledge handshake and sends it over the link. The acknowledge back to the device is withheld until the far end of the link has returned an acknowledge frame. Bytes that arrive from the link appear on the output port with a valid flag. They stay there until the local device acknowledges them.

Flow control runs end to end. The receiver returns an acknowledge frame only once its output register has been emptied by the local device, and a sender cannot start another data frame until that frame arrives. Two copies of the block wired back to back therefore form a credit-of-one byte pipe in each direction. The two directions operate concurrently. The line idles low. A data frame is two high bits, eight data bits least significant first, and a low stop bit. An acknowledge frame is one high bit followed by one low bit.

The receive line is synchronised and oversampled at four times the bit rate. The receiver realigns its sample phase on the leading edge of every frame. One input picks the fast or the slow link rate.

Top module: `slink_byte_bridge`

## Requirements
- R1: While `rst` is high at a rising clock edge, `link_tx` goes low, `out_valid` and `in_ack` clear, and any frame being sent or received is abandoned. After reset is released, neither the abandoned frame nor its byte appears on any port.
- R2: A data frame on `link_tx` has 11 bits: 1, 1, data bit 0 through data bit 7, then 0. `link_tx` is low whenever no frame is being sent.
- R3: An acknowledge frame on `link_tx` has 2 bits: 1 then 0.
- R4: A received byte is driven on `out_byte` with `out_valid` high. Both hold unchanged until `out_ack` is sampled high. `out_valid` is low from the following cycle.
- R5: `in_ack` rises only after an acknowledge frame has been received on `link_rx` for the byte taken from `in_byte`. It stays high while `in_valid` is high and falls one cycle after `in_valid` is sampled low.
- R6: The acknowledge frame for a received byte is sent only after `out_valid` has been cleared by `out_ack`. A remote sender therefore sees no acknowledge while the byte sits unread.
- R7: One link bit lasts `FAST_BIT_CLKS` clock cycles when `link_fast` is 1 and twice that when it is 0.
- R8: Transmit and receive run at the same time. A pending acknowledge frame goes out before a pending data frame, but only between frames and never inside one.
- R9: The receiver samples `link_rx` at four times the bit rate. It realigns on each frame's leading edge, so a frame starting at any clock phase is decoded correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| link_fast | input | 1 | 1 selects the fast link rate, 0 the half rate |
| in_byte | input | DATA_W | Byte offered by the local device for transmission |
| in_valid | input | 1 | `in_byte` is valid |
| in_ack | output | 1 | Remote end has confirmed receipt of the byte |
| out_byte | output | DATA_W | Byte received from the link |
| out_valid | output | 1 | `out_byte` holds an unread byte |
| out_ack | input | 1 | Local device has read `out_byte` |
| link_rx | input | 1 | Serial line from the remote end, asynchronous |
| link_tx | output | 1 | Serial line to the remote end |

## Verification
The bench connects two bridges back to back. It holds a received byte unread for a long time and checks that the sender's `in_ack` stays low; a design that acknowledged on local capture would raise it early. It starts data in both directions at once and at staggered times, so acknowledge frames must slot between data frames; a transmitter that cut a frame would corrupt a byte. It also drives the receive line directly with frames at odd phases and at the slow rate, where a receiver without per-frame realignment would sample on bit edges. A reset in the middle of a frame must leave nothing behind on the far side.

// File: rtl/slink_pkg.sv
package slink_pkg;
   // receiver oversampling factor (fixed by the sample-phase logic)
   localparam int unsigned OVS = 4;

   typedef enum logic [1:0] {
      IN_IDLE,   // waiting for the device to offer a byte
      IN_SEND,   // byte latched, waiting for a frame slot
      IN_WAIT,   // frame sent, waiting for the remote acknowledge
      IN_DONE    // acknowledge shown to the device
   } in_state_e;

   typedef enum logic {
      RX_IDLE,
      RX_BUSY
   } rx_state_e;
endpackage

// File: rtl/slink_tick_gen.sv
module slink_tick_gen #(
   parameter int unsigned FAST_DIV = 1
) (
   input  logic clk,
   input  logic rst,
   input  logic fast,
   output logic smp_tick,
   output logic bit_tick
);
   logic [1:0] sub_q;

   generate
      if (FAST_DIV == 1) begin : g_unit
         logic half_q;
         always_ff @(posedge clk) begin
            if (rst) half_q <= 1'b0;
            else     half_q <= ~half_q;
         end
         assign smp_tick = fast | half_q;
      end else begin : g_count
         localparam int unsigned SLOW_DIV = 2 * FAST_DIV;
         localparam int unsigned CW       = $clog2(SLOW_DIV);
         logic [CW-1:0] cnt_q;
         logic [CW-1:0] lim;
         assign lim      = fast ? CW'(FAST_DIV - 1) : CW'(SLOW_DIV - 1);
         assign smp_tick = (cnt_q >= lim);
         always_ff @(posedge clk) begin
            if (rst)           cnt_q <= '0;
            else if (smp_tick) cnt_q <= '0;
            else               cnt_q <= cnt_q + 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)           sub_q <= '0;
      else if (smp_tick) sub_q <= sub_q + 1'b1;
   end

   assign bit_tick = smp_tick && (sub_q == 2'd3);
endmodule

// File: rtl/slink_tx.sv
module slink_tx #(
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          bit_tick,
   input  logic          ack_req,
   input  logic          data_req,
   input  logic [DW-1:0] data,
   output logic          ack_take,
   output logic          data_take,
   output logic          line
);
   localparam int unsigned FW = DW + 3;
   localparam int unsigned RW = $clog2(FW + 1);

   logic [FW-1:0] sreg_q;
   logic [RW-1:0] rem_q;
   logic          line_q;
   logic          slot_free;
   logic [FW-1:0] data_frame;

   // bit 0 leaves first: two start ones, data LSB first, zero stop
   assign data_frame = {1'b0, data, 2'b11};
   assign slot_free  = (rem_q == '0);
   assign ack_take   = bit_tick && slot_free && ack_req;
   assign data_take  = bit_tick && slot_free && !ack_req && data_req;
   assign line       = line_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         sreg_q <= '0;
         rem_q  <= '0;
         line_q <= 1'b0;
      end else if (bit_tick) begin
         if (!slot_free) begin
            line_q <= sreg_q[0];
            sreg_q <= sreg_q >> 1;
            rem_q  <= rem_q - 1'b1;
         end else if (ack_req) begin
            line_q <= 1'b1;
            sreg_q <= '0;
            rem_q  <= RW'(1);
         end else if (data_req) begin
            line_q <= 1'b1;
            sreg_q <= data_frame >> 1;
            rem_q  <= RW'(FW - 1);
         end else begin
            line_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/slink_rx.sv
module slink_rx
   import slink_pkg::*;
#(
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          smp_tick,
   input  logic          line_in,
   output logic          byte_stb,
   output logic [DW-1:0] byte_out,
   output logic          ack_stb
);
   localparam int unsigned FW = DW + 3;
   localparam int unsigned RW = $clog2(FW + 1);
   localparam logic [RW-1:0] LAST_IDX = RW'(FW - 1);
   // centre of a bit is reached when the phase moves from 1 to 2
   localparam logic [1:0] MID_PH = 2'(OVS / 2 - 1);

   logic [1:0]    sync_q;
   rx_state_e     st_q;
   logic [1:0]    ph_q;
   logic [RW-1:0] idx_q;
   logic [DW-1:0] shf_q;
   logic          cur;

   assign cur = sync_q[1];

   always_ff @(posedge clk) begin
      if (rst) sync_q <= '0;
      else     sync_q <= {sync_q[0], line_in};
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q     <= RX_IDLE;
         ph_q     <= '0;
         idx_q    <= '0;
         shf_q    <= '0;
         byte_out <= '0;
         byte_stb <= 1'b0;
         ack_stb  <= 1'b0;
      end else begin
         byte_stb <= 1'b0;
         ack_stb  <= 1'b0;
         if (smp_tick) begin
            case (st_q)
               RX_IDLE: begin
                  if (cur) begin
                     st_q  <= RX_BUSY;
                     ph_q  <= '0;
                     idx_q <= '0;
                  end
               end
               default: begin
                  ph_q <= ph_q + 1'b1;
                  if (ph_q == MID_PH) begin
                     idx_q <= idx_q + 1'b1;
                     if (idx_q == '0) begin
                        if (!cur) st_q <= RX_IDLE;
                     end else if (idx_q == RW'(1)) begin
                        if (!cur) begin
                           ack_stb <= 1'b1;
                           st_q    <= RX_IDLE;
                        end
                     end else if (idx_q == LAST_IDX) begin
                        if (!cur) begin
                           byte_stb <= 1'b1;
                           byte_out <= shf_q;
                        end
                        st_q <= RX_IDLE;
                     end else begin
                        shf_q <= {cur, shf_q[DW-1:1]};
                     end
                  end
               end
            endcase
         end
      end
   end
endmodule

// File: rtl/slink_byte_bridge.sv
module slink_byte_bridge
   import slink_pkg::*;
#(
   parameter int unsigned DATA_W        = 8,
   parameter int unsigned FAST_BIT_CLKS = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              link_fast,
   input  logic [DATA_W-1:0] in_byte,
   input  logic              in_valid,
   output logic              in_ack,
   output logic [DATA_W-1:0] out_byte,
   output logic              out_valid,
   input  logic              out_ack,
   input  logic              link_rx,
   output logic              link_tx
);
   localparam int unsigned SMP_DIV = FAST_BIT_CLKS / OVS;

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be at least 1");
      end
      if ((FAST_BIT_CLKS < OVS) || (FAST_BIT_CLKS % OVS != 0)) begin : g_bad_rate
         $error("FAST_BIT_CLKS must be a nonzero multiple of the oversampling factor");
      end
   endgenerate

   logic              smp_tick, bit_tick;
   logic              tx_ack_take, tx_data_take;
   logic              rx_byte_stb, rx_ack_stb;
   logic [DATA_W-1:0] rx_byte;
   in_state_e         in_st_q;
   logic [DATA_W-1:0] in_hold_q;
   logic              ack_pend_q;
   logic              out_valid_q;
   logic [DATA_W-1:0] out_byte_q;

   slink_tick_gen #(.FAST_DIV(SMP_DIV)) i_ticks (
      .clk(clk), .rst(rst), .fast(link_fast),
      .smp_tick(smp_tick), .bit_tick(bit_tick)
   );

   slink_tx #(.DW(DATA_W)) i_tx (
      .clk(clk), .rst(rst), .bit_tick(bit_tick),
      .ack_req(ack_pend_q), .data_req(in_st_q == IN_SEND), .data(in_hold_q),
      .ack_take(tx_ack_take), .data_take(tx_data_take), .line(link_tx)
   );

   slink_rx #(.DW(DATA_W)) i_rx (
      .clk(clk), .rst(rst), .smp_tick(smp_tick), .line_in(link_rx),
      .byte_stb(rx_byte_stb), .byte_out(rx_byte), .ack_stb(rx_ack_stb)
   );

   // input port: acknowledge only after the remote end confirms
   always_ff @(posedge clk) begin
      if (rst) begin
         in_st_q   <= IN_IDLE;
         in_hold_q <= '0;
      end else begin
         case (in_st_q)
            IN_IDLE: if (in_valid) begin
               in_hold_q <= in_byte;
               in_st_q   <= IN_SEND;
            end
            IN_SEND: if (tx_data_take) in_st_q <= IN_WAIT;
            IN_WAIT: if (rx_ack_stb)   in_st_q <= IN_DONE;
            default: if (!in_valid)    in_st_q <= IN_IDLE;
         endcase
      end
   end
   assign in_ack = (in_st_q == IN_DONE);

   // output port: register freed by the device releases the link acknowledge
   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid_q <= 1'b0;
         out_byte_q  <= '0;
         ack_pend_q  <= 1'b0;
      end else begin
         if (tx_ack_take) ack_pend_q <= 1'b0;
         if (rx_byte_stb) begin
            out_valid_q <= 1'b1;
            out_byte_q  <= rx_byte;
         end else if (out_valid_q && out_ack) begin
            out_valid_q <= 1'b0;
            ack_pend_q  <= 1'b1;
         end
      end
   end
   assign out_valid = out_valid_q;
   assign out_byte  = out_byte_q;
endmodule

// File: rtl/slink_bridge_chk.sv
module slink_bridge_chk #(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic              in_ack,
   input logic              out_valid,
   input logic              out_ack,
   input logic [DATA_W-1:0] out_byte,
   input logic              link_tx,
   input logic              rx_ack_stb,
   input logic              tx_ack_take
);
   // R1: first cycle after reset shows the idle state
   p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (!link_tx && !out_valid && !in_ack));

   // R4: unread byte is held
   p_out_hold_r4: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ack) |=> (out_valid && $stable(out_byte)));

   // R5: acknowledge to the device follows a received acknowledge frame
   p_in_ack_remote_r5: assert property (@(posedge clk) disable iff (rst)
      $rose(in_ack) |-> $past(rx_ack_stb));

   // R5: acknowledge held while the device keeps its strobe up
   p_in_ack_held_r5: assert property (@(posedge clk) disable iff (rst)
      (in_ack && in_valid) |=> in_ack);

   // R6: link acknowledge only leaves once the output register is empty
   p_ack_when_free_r6: assert property (@(posedge clk) disable iff (rst)
      tx_ack_take |-> !out_valid);
endmodule

bind slink_byte_bridge slink_bridge_chk #(.DATA_W(DATA_W)) i_slink_chk (
   .clk(clk), .rst(rst), .in_valid(in_valid), .in_ack(in_ack),
   .out_valid(out_valid), .out_ack(out_ack), .out_byte(out_byte),
   .link_tx(link_tx), .rx_ack_stb(rx_ack_stb), .tx_ack_take(tx_ack_take)
);

// File: tb/test_slink_byte_bridge.sv
module test_slink_byte_bridge;
   localparam int CLK_PERIOD = 10;
   localparam int BITC       = 4;
   localparam int WD_CYCLES  = 60000;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       fast = 1'b1;
   logic       ovr = 1'b0;
   logic       tb_line = 1'b0;
   logic [7:0] a_in = '0, b_in = '0;
   logic       a_iv = 1'b0, b_iv = 1'b0;
   logic       a_oa = 1'b0, b_oa = 1'b0;
   logic       a_ia, b_ia, a_ov, b_ov, a_tx, b_tx;
   logic [7:0] a_out, b_out;
   logic       a_rx;
   int         n_run = 0, n_fail = 0;
   bit         done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;
   assign a_rx = ovr ? tb_line : b_tx;

   slink_byte_bridge #(.DATA_W(8), .FAST_BIT_CLKS(BITC)) i_slink_byte_bridge (
      .clk(clk), .rst(rst), .link_fast(fast),
      .in_byte(a_in), .in_valid(a_iv), .in_ack(a_ia),
      .out_byte(a_out), .out_valid(a_ov), .out_ack(a_oa),
      .link_rx(a_rx), .link_tx(a_tx));

   slink_byte_bridge #(.DATA_W(8), .FAST_BIT_CLKS(BITC)) i_peer (
      .clk(clk), .rst(rst), .link_fast(fast),
      .in_byte(b_in), .in_valid(b_iv), .in_ack(b_ia),
      .out_byte(b_out), .out_valid(b_ov), .out_ack(b_oa),
      .link_rx(a_tx), .link_tx(b_tx));

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst = 1'b1;
      repeat (4) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
   endtask

   task automatic pulse_b_ack();
      b_oa = 1'b1; @(negedge clk); b_oa = 1'b0;
   endtask

   task automatic pulse_a_ack();
      a_oa = 1'b1; @(negedge clk); a_oa = 1'b0;
   endtask

   // R1: idle state after reset
   task automatic t_reset_state();
      do_reset();
      check(!a_tx && !a_ov && !a_ia, "R1 reset idle", {a_tx, a_ov, a_ia}, 0);
   endtask

   // R2, R3, R5: frame shapes and the final handshake
   task automatic t_frame_format();
      logic [10:0] f = '0;
      logic [2:0]  g = '0;
      a_in = 8'hA5; a_iv = 1'b1;
      for (int i = 0; i < 200 && !a_tx; i++) @(negedge clk);
      for (int k = 0; k < 11; k++) begin
         if (k == 0) @(negedge clk); else repeat (BITC) @(negedge clk);
         f[k] = a_tx;
      end
      check(f == {1'b0, 8'hA5, 2'b11}, "R2 data frame bits", f, {1'b0, 8'hA5, 2'b11});
      for (int i = 0; i < 200 && !b_ov; i++) @(negedge clk);
      check(b_ov && b_out == 8'hA5, "R2 byte decoded", b_out, 8'hA5);
      pulse_b_ack();
      for (int i = 0; i < 200 && !b_tx; i++) @(negedge clk);
      for (int k = 0; k < 3; k++) begin
         if (k == 0) @(negedge clk); else repeat (BITC) @(negedge clk);
         g[k] = b_tx;
      end
      check(g == 3'b001, "R3 ack frame bits then idle", g, 3'b001);
      for (int i = 0; i < 200 && !a_ia; i++) @(negedge clk);
      check(a_ia, "R5 in_ack after remote ack", a_ia, 1);
      repeat (3) @(negedge clk);
      check(a_ia, "R5 in_ack held while in_valid", a_ia, 1);
      a_iv = 1'b0;
      @(negedge clk);
      check(!a_ia, "R5 in_ack falls after in_valid low", a_ia, 0);
   endtask

   // R4, R6: byte held unread keeps the sender waiting
   task automatic t_end_to_end(input logic [7:0] d, input int hold);
      a_in = d; a_iv = 1'b1;
      for (int i = 0; i < 300 && !b_ov; i++) @(negedge clk);
      check(b_ov && b_out == d, "R4 byte presented", b_out, d);
      repeat (hold) @(negedge clk);
      check(b_ov && b_out == d, "R4 byte held until out_ack", b_out, d);
      check(!a_ia, "R6 no remote ack while unread", a_ia, 0);
      pulse_b_ack();
      check(!b_ov, "R4 out_valid clears after out_ack", b_ov, 0);
      for (int i = 0; i < 200 && !a_ia; i++) @(negedge clk);
      check(a_ia, "R6 ack follows read", a_ia, 1);
      a_iv = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   // R7: width of the two start bits at each rate
   task automatic t_speed(input logic f_sel);
      int run = 0;
      do_reset();
      fast = f_sel;
      @(negedge clk);
      a_in = 8'h00; a_iv = 1'b1;
      for (int i = 0; i < 300 && !a_tx; i++) @(negedge clk);
      while (a_tx && run < 100) begin run++; @(negedge clk); end
      check(run == 2 * BITC * (f_sel ? 1 : 2), "R7 bit period", run, 2 * BITC * (f_sel ? 1 : 2));
      for (int i = 0; i < 600 && !b_ov; i++) @(negedge clk);
      check(b_ov && b_out == 8'h00, "R7 byte at selected rate", b_out, 0);
      pulse_b_ack();
      for (int i = 0; i < 600 && !a_ia; i++) @(negedge clk);
      check(a_ia, "R7 ack at selected rate", a_ia, 1);
      a_iv = 1'b0;
      repeat (2) @(negedge clk);
      fast = 1'b1;
   endtask

   // R8: both directions at once, acks interleaved between data frames
   task automatic t_duplex(input logic [7:0] da, input logic [7:0] db, input int skew);
      bit got_a = 0, got_b = 0, ia = 0, ib = 0;
      a_in = da; a_iv = 1'b1;
      repeat (skew) @(negedge clk);
      b_in = db; b_iv = 1'b1;
      for (int i = 0; i < 800 && !(got_a && got_b && ia && ib); i++) begin
         @(negedge clk);
         if (b_ov && !got_b) begin
            got_b = 1;
            check(b_out == da, "R8 A to B byte", b_out, da);
            b_oa = 1'b1;
         end else b_oa = 1'b0;
         if (a_ov && !got_a) begin
            got_a = 1;
            check(a_out == db, "R8 B to A byte", a_out, db);
            a_oa = 1'b1;
         end else a_oa = 1'b0;
         if (a_ia) ia = 1;
         if (b_ia) ib = 1;
      end
      a_oa = 1'b0; b_oa = 1'b0;
      check(got_a && got_b && ia && ib, "R8 both handshakes complete", {got_a, got_b, ia, ib}, 4'hF);
      a_iv = 1'b0; b_iv = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   // R1: reset in the middle of a frame
   task automatic t_reset_mid();
      a_in = 8'hFF; a_iv = 1'b1;
      for (int i = 0; i < 200 && !a_tx; i++) @(negedge clk);
      repeat (6) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      check(!a_tx && !a_ia, "R1 line idle in reset", {a_tx, a_ia}, 0);
      a_iv = 1'b0;
      @(negedge clk);
      rst = 1'b0;
      repeat (150) @(negedge clk);
      check(!b_ov, "R1 partial frame dropped", b_ov, 0);
      check(!a_tx && !a_ia, "R1 nothing resent", {a_tx, a_ia}, 0);
   endtask

   // R9: frames driven straight onto the receive line at odd phases
   task automatic t_realign(input logic [7:0] d, input int gap, input logic f_sel);
      logic [10:0] fr;
      int          bp;
      fr = {1'b0, d, 2'b11};
      bp = f_sel ? BITC : 2 * BITC;
      fast = f_sel;
      ovr  = 1'b1;
      tb_line = 1'b0;
      repeat (gap) @(negedge clk);
      #(CLK_PERIOD/4);
      for (int k = 0; k < 11; k++) begin
         tb_line = fr[k];
         repeat (bp) @(negedge clk);
      end
      tb_line = 1'b0;
      for (int i = 0; i < 40 && !a_ov; i++) @(negedge clk);
      check(a_ov && a_out == d, "R9 realigned decode", a_out, d);
      pulse_a_ack();
      repeat (6 * bp) @(negedge clk);
   endtask

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: run did not finish actual=0 expected=1");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      t_reset_state();
      t_frame_format();
      t_end_to_end(8'h3C, 80);
      t_end_to_end(8'hC3, 5);
      t_speed(1'b1);
      t_speed(1'b0);
      do_reset();
      t_duplex(8'h5A, 8'hC3, 0);
      t_duplex(8'h81, 8'h7E, 9);
      t_reset_mid();
      do_reset();
      t_realign(8'h96, 1, 1'b1);
      t_realign(8'h3B, 2, 1'b1);
      t_realign(8'hE1, 3, 1'b0);
      ovr = 1'b0; fast = 1'b1;
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule